// File: doc/BRIEF.md
# Sixteen-Channel LED PWM Driver with Group Dimming and Blinking

This block produces the on/off drive bits for sixteen LED channels. A shared fast counter gives every channel its own 8-bit pulse-width modulation, with a duty of code/256 of each 256-tick period. Each channel has a 2-bit mode. The mode turns the channel off, holds it fully on, runs it from its own duty value, or runs it from its own duty value gated by a shared group signal.

The group signal comes from one of two generators, chosen by a dim/blink select. The dimmer is a slow PWM whose step counter advances once every two fast periods, so one dimming period spans 512 fast periods. The blinker has a programmable period: a prescaler of `BLINK_PRE` ticks feeds a divider of (frequency code + 1), which steps a 256-phase counter. In both cases the group duty code sets the on fraction as code/256.

All counting advances on a clock-enable tick. While the oscillator-off input is set, the counters are held at zero, the duty shadows follow their inputs, and every output is dark. Outputs also stay dark after reset until that input is seen clear. New duty and frequency values are loaded into shadows only at the period boundary of the counter that uses them.

Top module: `ledgrp_drive`

## Requirements
- R1: While reset is asserted, and after reset until `osc_off` has been sampled low, every bit of `drive` is 0. While `osc_off` is 1, every bit of `drive` is 0 whatever the channel modes are.
- R2: Channel i takes its mode from `ch_mode[2i+1:2i]`. Mode 00 keeps the channel at 0. Mode 01 keeps it at 1 every cycle with no PWM.
- R3: Channel i takes its duty from `ch_duty[8i+7:8i]`. In mode 10, while ticking every cycle, the channel is high for exactly D of every 256 cycles. D=0 keeps it low, and D=255 gives 255 high cycles of 256.
- R4: In mode 11 with `blink_sel`=0, the group is on for the first 2M fast periods of each 512-fast-period dimming period, where M is `grp_duty`. During that window the channel shows 2M pulses of its own PWM. M=0 gives no pulse. `grp_freq` has no effect in this mode.
- R5: In mode 11 with `blink_sel`=1, the group signal has a period of 256*(F+1)*BLINK_PRE ticks, where F is `grp_freq`. It is on while its phase, which advances once every (F+1)*BLINK_PRE ticks, is below `grp_duty`. The drive is that group signal ANDed with the channel's own PWM.
- R6: A change to a channel's duty takes effect at the next fast-period boundary. Every high pulse therefore has the full width of either the old or the new duty.
- R7: The counters advance only on cycles with `tick_en`=1. With the tick held low, `drive` stays constant. With a tick every other cycle, every period stretches by a factor of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable that advances all counters |
| osc_off | input | 1 | 1 stops the counters and darkens every output |
| blink_sel | input | 1 | Group source: 0 dimmer, 1 blinker |
| grp_duty | input | 8 | Group on-fraction code |
| grp_freq | input | 8 | Blink period code |
| ch_duty | input | NUM_CH*8 | Packed per-channel duty codes |
| ch_mode | input | NUM_CH*2 | Packed per-channel 2-bit modes |
| drive | output | NUM_CH | Registered channel drive bits |

## Verification
The hardest case to reach is a duty change that lands in the middle of a pulse. The point to show is that the shadow loads the new value only at the boundary and never cuts the running pulse short. The bench changes the duty from 200 to 10 partway through a pulse and measures the width of every completed pulse. Dimming windows last 65536 ticks per half period and more, so they are too long to sweep in full. The bench therefore starts the counters from zero by releasing the oscillator-off input, then counts pulse edges inside the first group window. Blink counts are compared with a model summed over whole blink periods, which makes the comparison independent of the start offset.

// File: rtl/ledgrp_pkg.sv
package ledgrp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ON  = 2'b01,
    MODE_IND = 2'b10,
    MODE_GRP = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/ledgrp_fastcnt.sv
module ledgrp_fastcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt_d;

  assign wrap = run && tick && (cnt == LAST);

  always_comb begin
    cnt_d = cnt;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R7: without a tick the fast counter holds
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
  // R3: the counter returns to zero after its last value
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/ledgrp_group.sv
module ledgrp_group #(
  parameter int W         = 8,
  parameter int DIM_SUB_W = 1,
  parameter int BLINK_PRE = 4167
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         fast_wrap,
  input  logic         blink_sel,
  input  logic [W-1:0] grp_duty,
  input  logic [W-1:0] grp_freq,
  output logic         grp_on
);
  localparam int DCW = W + DIM_SUB_W;
  localparam int PRE_W = (BLINK_PRE > 1) ? $clog2(BLINK_PRE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(BLINK_PRE - 1);
  localparam logic [DCW-1:0] DIM_LAST = {DCW{1'b1}};
  localparam logic [W-1:0]   PH_LAST  = {W{1'b1}};

  // dimming generator
  logic [DCW-1:0] dcnt, dcnt_d;
  logic [W-1:0]   dim_duty_sh, dim_duty_sh_d;
  logic           dim_wrap, dim_on;

  // blink generator
  logic [PRE_W-1:0] pcnt, pcnt_d;
  logic [W-1:0]     scnt, scnt_d;
  logic [W-1:0]     phase, phase_d;
  logic [W-1:0]     bl_duty_sh, bl_duty_sh_d;
  logic [W-1:0]     bl_freq_sh, bl_freq_sh_d;
  logic             pre_strobe, step, blink_wrap, blink_on;

  assign dim_wrap   = fast_wrap && (dcnt == DIM_LAST);
  assign dim_on     = dcnt[DCW-1 -: W] < dim_duty_sh;

  assign pre_strobe = run && tick && (pcnt == PRE_LAST);
  assign step       = pre_strobe && (scnt == bl_freq_sh);
  assign blink_wrap = step && (phase == PH_LAST);
  assign blink_on   = phase < bl_duty_sh;

  assign grp_on     = blink_sel ? blink_on : dim_on;

  always_comb begin
    dcnt_d        = dcnt;
    dim_duty_sh_d = dim_duty_sh;
    if (!run) begin
      dcnt_d        = '0;
      dim_duty_sh_d = grp_duty;
    end else begin
      if (fast_wrap) dcnt_d        = dcnt + 1'b1;
      if (dim_wrap)  dim_duty_sh_d = grp_duty;
    end
  end

  always_comb begin
    pcnt_d       = pcnt;
    scnt_d       = scnt;
    phase_d      = phase;
    bl_duty_sh_d = bl_duty_sh;
    bl_freq_sh_d = bl_freq_sh;
    if (!run) begin
      pcnt_d       = '0;
      scnt_d       = '0;
      phase_d      = '0;
      bl_duty_sh_d = grp_duty;
      bl_freq_sh_d = grp_freq;
    end else if (tick) begin
      pcnt_d = pre_strobe ? '0 : pcnt + 1'b1;
      if (pre_strobe) begin
        if (step) begin
          scnt_d  = '0;
          phase_d = phase + 1'b1;
        end else begin
          scnt_d  = scnt + 1'b1;
        end
      end
      if (blink_wrap) begin
        bl_duty_sh_d = grp_duty;
        bl_freq_sh_d = grp_freq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt        <= '0;
      dim_duty_sh <= {W{1'b1}};
      pcnt        <= '0;
      scnt        <= '0;
      phase       <= '0;
      bl_duty_sh  <= {W{1'b1}};
      bl_freq_sh  <= '0;
    end else begin
      dcnt        <= dcnt_d;
      dim_duty_sh <= dim_duty_sh_d;
      pcnt        <= pcnt_d;
      scnt        <= scnt_d;
      phase       <= phase_d;
      bl_duty_sh  <= bl_duty_sh_d;
      bl_freq_sh  <= bl_freq_sh_d;
    end
  end

  // R4: the dimming step counter moves only on fast-period boundaries
  p_dim_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fast_wrap) |=> $stable(dcnt));
  // R5: the blink phase moves only on a prescaler strobe
  p_blink_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pre_strobe) |=> $stable(phase));
  // R5: blink shadows change only at a blink period boundary
  p_blink_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !blink_wrap) |=> ($stable(bl_freq_sh) && $stable(bl_duty_sh)));
endmodule

// File: rtl/ledgrp_chan.sv
module ledgrp_chan
  import ledgrp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         fast_wrap,
  input  logic [W-1:0] fcnt,
  input  logic         grp_on,
  input  logic [W-1:0] duty_in,
  input  logic [1:0]   mode_in,
  output logic         drive_q
);
  logic [W-1:0] duty_sh, duty_sh_d;
  logic         ind_on, drive_d;
  drv_mode_e    mode;

  assign mode   = drv_mode_e'(mode_in);
  assign ind_on = fcnt < duty_sh;

  always_comb begin
    duty_sh_d = duty_sh;
    if (!run || fast_wrap) duty_sh_d = duty_in;
  end

  always_comb begin
    drive_d = 1'b0;
    if (run) begin
      unique case (mode)
        MODE_OFF: drive_d = 1'b0;
        MODE_ON:  drive_d = 1'b1;
        MODE_IND: drive_d = ind_on;
        MODE_GRP: drive_d = ind_on && grp_on;
        default:  drive_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh <= '0;
      drive_q <= 1'b0;
    end else begin
      duty_sh <= duty_sh_d;
      drive_q <= drive_d;
    end
  end

  // R1: a stopped oscillator darkens the channel
  p_dark_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !drive_q);
  // R2: mode 00 keeps the output low, mode 01 keeps it high
  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00) |=> !drive_q);
  p_mode_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_in == 2'b01) |=> drive_q);
  // R6: the duty shadow moves only at a fast-period boundary
  p_shadow_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fast_wrap) |=> $stable(duty_sh));
endmodule

// File: rtl/ledgrp_drive.sv
module ledgrp_drive
  import ledgrp_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int DUTY_W    = 8,
  parameter int DIM_SUB_W = 1,
  parameter int BLINK_PRE = 4167
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     osc_off,
  input  logic                     blink_sel,
  input  logic [DUTY_W-1:0]        grp_duty,
  input  logic [DUTY_W-1:0]        grp_freq,
  input  logic [NUM_CH*DUTY_W-1:0] ch_duty,
  input  logic [NUM_CH*2-1:0]      ch_mode,
  output logic [NUM_CH-1:0]        drive
);
  logic              osc_q;
  logic              run;
  logic [DUTY_W-1:0] fcnt;
  logic              fast_wrap;
  logic              grp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_q <= 1'b1;
    else        osc_q <= osc_off;
  end

  assign run = !osc_q;

  ledgrp_fastcnt #(.W(DUTY_W)) u_fast (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick_en),
    .cnt   (fcnt),
    .wrap  (fast_wrap)
  );

  ledgrp_group #(
    .W         (DUTY_W),
    .DIM_SUB_W (DIM_SUB_W),
    .BLINK_PRE (BLINK_PRE)
  ) u_group (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick_en),
    .fast_wrap (fast_wrap),
    .blink_sel (blink_sel),
    .grp_duty  (grp_duty),
    .grp_freq  (grp_freq),
    .grp_on    (grp_on)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ledgrp_chan #(.W(DUTY_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .fast_wrap (fast_wrap),
      .fcnt      (fcnt),
      .grp_on    (grp_on),
      .duty_in   (ch_duty[i*DUTY_W +: DUTY_W]),
      .mode_in   (ch_mode[i*2 +: 2]),
      .drive_q   (drive[i])
    );
  end

  // R1: stopped oscillator means all outputs dark
  p_all_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    osc_q |=> (drive == '0));
endmodule

// File: tb/ledgrp_drive_bench.sv
module ledgrp_drive_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick_en = 1'b1;
  logic            tick_div = 1'b0;
  logic            tick_hold = 1'b0;
  logic            osc_off = 1'b1;
  logic            blink_sel = 1'b0;
  logic [7:0]      grp_duty = 8'hFF;
  logic [7:0]      grp_freq = 8'h00;
  logic [NCH*8-1:0] ch_duty = '0;
  logic [NCH*2-1:0] ch_mode = '0;
  logic [NCH-1:0]  drive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_hold)     tick_en <= 1'b0;
    else if (tick_div) tick_en <= ~tick_en;
    else               tick_en <= 1'b1;
  end

  ledgrp_drive #(.NUM_CH(NCH), .DUTY_W(8), .DIM_SUB_W(1), .BLINK_PRE(1)) u_ledgrp_drive (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_off(osc_off),
    .blink_sel(blink_sel), .grp_duty(grp_duty), .grp_freq(grp_freq),
    .ch_duty(ch_duty), .ch_mode(ch_mode), .drive(drive)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ch(input int i, input logic [1:0] m, input logic [7:0] d);
    ch_mode[2*i +: 2] = m;
    ch_duty[8*i +: 8] = d;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NCH; i++) set_ch(i, 2'b00, 8'h00);
  endtask

  // stop counters, then restart them from zero with current settings
  task automatic restart();
    @(negedge clk) osc_off = 1'b1;
    repeat (4) @(negedge clk);
    osc_off = 1'b0;
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  function automatic int blink_model(int cd, int gd, int f, int len);
    int n = 0;
    for (int t = 0; t < len; t++)
      if (((t % 256) < cd) && (((t / (f + 1)) % 256) < gd)) n++;
    return n;
  endfunction

  task automatic t_reset();
    ch_mode = '1;
    #1;
    check("R1 drive in reset", drive, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    begin
      int hi = 0;
      for (int k = 0; k < 20; k++) begin sample(); if (drive != 0) hi++; end
      check("R1 dark after reset, osc_off still set", hi, 0);
    end
  endtask

  task automatic t_osc_force();
    int hi = 0;
    for (int i = 0; i < NCH; i++) set_ch(i, 2'b01, 8'h80);
    for (int k = 0; k < 300; k++) begin sample(); if (drive != 0) hi++; end
    check("R1 osc_off forces all off in mode 01", hi, 0);
    @(negedge clk) osc_off = 1'b0;
    repeat (3) sample();
    check("R2 mode 01 fully on on all channels", drive, 16'hFFFF);
  endtask

  task automatic t_modes();
    int cnt [NCH];
    int exp [6] = '{0, 512, 0, 510, 200, 200};
    clear_all();
    blink_sel = 1'b0; grp_duty = 8'hFF;
    set_ch(0, 2'b00, 8'hFF);
    set_ch(1, 2'b01, 8'h00);
    set_ch(2, 2'b10, 8'h00);
    set_ch(3, 2'b10, 8'hFF);
    set_ch(4, 2'b10, 8'd100);
    set_ch(5, 2'b11, 8'd100);
    restart();
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    repeat (4) sample();
    for (int k = 0; k < 512; k++) begin
      sample();
      for (int i = 0; i < NCH; i++) if (drive[i]) cnt[i]++;
    end
    check("R2 mode 00 stays off", cnt[0], exp[0]);
    check("R2 mode 01 always on", cnt[1], exp[1]);
    check("R3 duty 0 never on", cnt[2], exp[2]);
    check("R3 duty 255 gives 255/256", cnt[3], exp[3]);
    check("R3 duty 100 high cycles", cnt[4], exp[4]);
    check("R4 mode 11 inside full group window", cnt[5], exp[5]);
  endtask

  task automatic dim_edges(input logic [7:0] m, output int e0, output int e1);
    logic [NCH-1:0] prev;
    clear_all();
    blink_sel = 1'b0; grp_duty = m; grp_freq = 8'd200;
    set_ch(0, 2'b11, 8'd16);
    set_ch(1, 2'b10, 8'd16);
    restart();
    e0 = 0; e1 = 0; prev = '0;
    for (int k = 0; k < 2048; k++) begin
      sample();
      if (drive[0] && !prev[0]) e0++;
      if (drive[1] && !prev[1]) e1++;
      prev = drive;
    end
  endtask

  task automatic t_dim();
    int e0, e1;
    dim_edges(8'd2, e0, e1);
    check("R4 group M=2 gives 2M pulses, freq ignored", e0, 4);
    check("R3 ungated channel pulses in same window", e1, 8);
    dim_edges(8'd0, e0, e1);
    check("R4 group M=0 gives no pulse", e0, 0);
  endtask

  task automatic blink_run(input int gd, input int f, input int len);
    int c0 = 0, c1 = 0;
    clear_all();
    blink_sel = 1'b1; grp_duty = 8'(gd); grp_freq = 8'(f);
    set_ch(0, 2'b11, 8'd255);
    set_ch(1, 2'b11, 8'd128);
    restart();
    repeat (4) sample();
    for (int k = 0; k < len; k++) begin
      sample();
      if (drive[0]) c0++;
      if (drive[1]) c1++;
    end
    check("R5 blink ch0 high count vs model", c0, blink_model(255, gd, f, len));
    check("R5 blink ch1 high count vs model", c1, blink_model(128, gd, f, len));
  endtask

  task automatic t_blink();
    blink_run(64, 1, 1024);
    blink_run(128, 3, 2048);
    blink_sel = 1'b0;
  endtask

  task automatic t_update();
    int w = 0, bad = 0, short_seen = 0;
    clear_all();
    set_ch(0, 2'b10, 8'd200);
    restart();
    for (int k = 0; k < 1200; k++) begin
      if (k == 300) begin @(negedge clk); ch_duty[7:0] = 8'd10; end
      sample();
      if (drive[0]) w++;
      else if (w != 0) begin
        if (w == 10) short_seen++;
        else if (w != 200) bad++;
        w = 0;
      end
    end
    check("R6 no partial pulse after duty change", bad, 0);
    check("R6 new duty applied after boundary", short_seen > 0, 1);
  endtask

  task automatic t_tick();
    int hi = 0, moved = 0;
    logic [NCH-1:0] held;
    clear_all();
    set_ch(0, 2'b10, 8'd100);
    tick_div = 1'b1;
    restart();
    repeat (4) sample();
    for (int k = 0; k < 1024; k++) begin sample(); if (drive[0]) hi++; end
    check("R7 half-rate tick doubles period", hi, 400);
    @(negedge clk) tick_hold = 1'b1;
    repeat (3) sample();
    held = drive;
    for (int k = 0; k < 100; k++) begin sample(); if (drive != held) moved++; end
    check("R7 drive frozen without tick", moved, 0);
    @(negedge clk) begin tick_hold = 1'b0; tick_div = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_osc_force();
    t_modes();
    t_dim();
    t_blink();
    t_update();
    t_tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule